// File: doc/BRIEF.md
# Hadamard DC Coefficient Transform Unit

This unit applies the separable Hadamard transform used for the DC terms of block-based video coding. In the large-block mode it transforms a 4x4 array of luma DC values gathered from a macroblock predicted as one 16x16 intra unit. In the small-block mode it transforms one 2x2 array of chroma DC values, and it is started once for each of the two chroma planes. The Hadamard matrices are their own inverses up to a scale factor, so one datapath serves both the forward and the inverse transform. There is no direction input.

A one-cycle start pulse captures the coefficient array and the size selector. The unit then works through the result one column at a time. For each column it first forms the four first-stage sums (the input array multiplied by the Hadamard matrix) into holding registers. It then issues that column's outputs, one per cycle, through three adder/subtractors. Within a column the rows come out in the order 0, 1, 2, 3. With this order the first two adder/subtractors keep the same operation and the same operands for rows 0–1, and again for rows 2–3, which reduces switching in that part of the datapath.

The unit does no scaling and no quantization. Its outputs are four bits wider than its inputs, so no result can overflow.

Top module: `hdc_hadamard_dc`

## Requirements
- R1: While reset is held, and after it is released with no start pulse, `busy_o`, `out_valid_o` and `done_o` are all low.
- R2: Large-block mode (`size2_i`=0). Input element X[r][c] sits in bits [(r*4+c)*16 +: 16] of `coef_i`. The unit outputs Y = H·X·H. The rows of H are (+,+,+,+), (+,+,−,−), (+,−,−,+) and (+,−,+,−). Each Y[i][j] appears on `out_data_o`, with i on `out_row_o` and j on `out_col_o`.
- R3: Small-block mode (`size2_i`=1). Input element X[r][c] sits in bits [(r*2+c)*16 +: 16], and bits 64 and above are ignored. The unit outputs Y = H2·X·H2, with H2 = [[+1,+1],[+1,−1]]. Exactly four outputs appear, in the order (0,0), (1,0), (0,1), (1,1).
- R4: Timing. If start is sampled at clock edge E, the first output is valid after edge E+2. The outputs then follow one per cycle with no gaps: 16 in large-block mode and 4 in small-block mode.
- R5: `done_o` is high only together with the final output of a block. `busy_o` goes high after the accepted start, is low again in the cycle that `done_o` is high, and in that same cycle a new start is accepted.
- R6: A start pulse that arrives while `busy_o` is high is ignored. The running block finishes unchanged, and no further outputs follow it. The coefficients and the size are sampled only when a start is accepted.
- R7: Full-scale inputs (every element +32767, every element −32768, or a checkerboard of the two) give exact results on the 20-bit signed output.
- R8: Applying the transform twice returns 16·X in large-block mode and 4·X in small-block mode.
- R9: In large-block mode the columns are issued in the order 0 to 3, and the rows within each column in the order 0 to 3. For each row pair (0,1) and (2,3), the operands and operation of the first two adder/subtractors stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| start_i | input | 1 | One-cycle request to begin a block |
| size2_i | input | 1 | 1 selects the 2x2 mode, 0 selects the 4x4 mode; sampled with start |
| coef_i | input | 256 | Input array, 16 signed 16-bit elements, raster order |
| busy_o | output | 1 | A block is being processed |
| out_valid_o | output | 1 | `out_data_o` holds a result this cycle |
| out_data_o | output | 20 | Signed transform result |
| out_row_o | output | 2 | Row index of the current result |
| out_col_o | output | 2 | Column index of the current result |
| done_o | output | 1 | High together with the last result of a block |

## Verification
Single-impulse inputs are swept over every position in both modes. Each impulse shows that one input element reaches every output with the sign of its own row and column of the matrix, so a swapped index or a wrong sign shows up. Random full-range arrays exercise the sums across all terms. Full-scale uniform and checkerboard arrays push the two extreme outputs to the limit of the output width. Feeding the outputs back in as inputs checks the self-inverse property. Separate runs cover a start pulse during a running block and a new start accepted in the cycle that `done_o` is high.

// File: rtl/hdc_pkg.sv
`timescale 1ns/1ps
package hdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } hdc_state_e;

  // Negative-sign mask of the 4x4 Hadamard matrix, bit index {row, col}.
  localparam logic [15:0] H4_NEG = 16'b1010_0110_1100_0000;

  function automatic logic h4_neg(input logic [1:0] i, input logic [1:0] k);
    return H4_NEG[{i, k}];
  endfunction

endpackage

// File: rtl/hdc_colsum.sv
`timescale 1ns/1ps
module hdc_colsum
  import hdc_pkg::*;
#(
  parameter  int IN_W  = 16,
  localparam int SUM_W = IN_W + 2,
  localparam int NCOEF = 16
) (
  input  logic [NCOEF*IN_W-1:0]   coef_i,
  input  logic [1:0]              col_i,
  input  logic                    size2_i,
  output logic signed [SUM_W-1:0] t_o [4]
);

  logic signed [SUM_W-1:0] t4 [4];
  logic signed [SUM_W-1:0] t2 [2];

  for (genvar r = 0; r < 4; r++) begin : g_big
    logic signed [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int c = 0; c < 4; c++) begin
        if (h4_neg(col_i, 2'(c)))
          acc = acc - SUM_W'($signed(coef_i[(r*4+c)*IN_W +: IN_W]));
        else
          acc = acc + SUM_W'($signed(coef_i[(r*4+c)*IN_W +: IN_W]));
      end
    end
    assign t4[r] = acc;
  end

  for (genvar r = 0; r < 2; r++) begin : g_small
    logic signed [SUM_W-1:0] e0, e1;
    assign e0 = SUM_W'($signed(coef_i[(r*2)*IN_W +: IN_W]));
    assign e1 = SUM_W'($signed(coef_i[(r*2+1)*IN_W +: IN_W]));
    assign t2[r] = col_i[0] ? (e0 - e1) : (e0 + e1);
  end

  always_comb begin
    if (size2_i) begin
      t_o[0] = t2[0];
      t_o[1] = t2[1];
      t_o[2] = '0;
      t_o[3] = '0;
    end else begin
      for (int r = 0; r < 4; r++) t_o[r] = t4[r];
    end
  end

endmodule

// File: rtl/hdc_butterfly.sv
`timescale 1ns/1ps
module hdc_butterfly #(
  parameter  int SUM_W = 18,
  localparam int OUT_W = SUM_W + 2
) (
  input  logic signed [SUM_W-1:0] t_i [4],
  input  logic [1:0]              sel_i,
  output logic signed [OUT_W-1:0] y_o
);

  logic signed [SUM_W:0] s0, s1;
  logic                  pair_sub;
  logic                  final_sub;

  assign pair_sub  = sel_i[1];
  assign final_sub = sel_i[1] ^ sel_i[0];

  // Adder/subtractors 0 and 1: operation depends only on the row pair.
  always_comb begin
    if (pair_sub) begin
      s0 = (SUM_W+1)'(t_i[0]) - (SUM_W+1)'(t_i[1]);
      s1 = (SUM_W+1)'(t_i[2]) - (SUM_W+1)'(t_i[3]);
    end else begin
      s0 = (SUM_W+1)'(t_i[0]) + (SUM_W+1)'(t_i[1]);
      s1 = (SUM_W+1)'(t_i[2]) + (SUM_W+1)'(t_i[3]);
    end
  end

  // Adder/subtractor 2.
  assign y_o = final_sub ? (OUT_W'(s0) - OUT_W'(s1)) : (OUT_W'(s0) + OUT_W'(s1));

endmodule

// File: rtl/hdc_seq.sv
`timescale 1ns/1ps
module hdc_seq
  import hdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       size2_i,
  output hdc_state_e state_o,
  output logic       size2_o,
  output logic [1:0] row_o,
  output logic [1:0] col_o,
  output logic [1:0] sel_o,
  output logic [1:0] next_col_o,
  output logic       last_o,
  output logic       cap_o,
  output logic       load_o
);

  hdc_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic       size2_q;
  logic       col_end;

  assign cap_o   = (state_q == ST_IDLE) && start_i;
  assign last_o  = size2_q ? (cnt_q == 4'd3) : (cnt_q == 4'd15);
  assign col_end = size2_q ? cnt_q[0] : (cnt_q[1:0] == 2'd3);
  assign row_o   = size2_q ? {1'b0, cnt_q[0]} : cnt_q[1:0];
  assign col_o   = size2_q ? {1'b0, cnt_q[1]} : cnt_q[3:2];
  assign sel_o   = size2_q ? {cnt_q[0], 1'b0} : cnt_q[1:0];
  assign load_o  = (state_q == ST_LOAD) || ((state_q == ST_RUN) && col_end && !last_o);
  assign next_col_o = (state_q == ST_LOAD) ? 2'd0 : (col_o + 2'd1);
  assign state_o = state_q;
  assign size2_o = size2_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 4'd1;
        if (last_o) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      size2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (cap_o) size2_q <= size2_i;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> (cnt_q == $past(cnt_q) + 4'd1)); // R6

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(size2_q)); // R6

endmodule

// File: rtl/hdc_hadamard_dc.sv
`timescale 1ns/1ps
module hdc_hadamard_dc
  import hdc_pkg::*;
#(
  parameter  int IN_W  = 16,
  localparam int NCOEF = 16,
  localparam int SUM_W = IN_W + 2,
  localparam int OUT_W = IN_W + 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    size2_i,
  input  logic [NCOEF*IN_W-1:0]   coef_i,
  output logic                    busy_o,
  output logic                    out_valid_o,
  output logic signed [OUT_W-1:0] out_data_o,
  output logic [1:0]              out_row_o,
  output logic [1:0]              out_col_o,
  output logic                    done_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  hdc_state_e state;
  logic       size2_q, last, cap, load;
  logic [1:0] row, col, sel, next_col;

  hdc_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_s),
    .start_i    (start_i),
    .size2_i    (size2_i),
    .state_o    (state),
    .size2_o    (size2_q),
    .row_o      (row),
    .col_o      (col),
    .sel_o      (sel),
    .next_col_o (next_col),
    .last_o     (last),
    .cap_o      (cap),
    .load_o     (load)
  );

  // Coefficient buffer.
  logic [NCOEF*IN_W-1:0] coef_q;
  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s)   coef_q <= '0;
    else if (cap) coef_q <= coef_i;
  end

  // First-stage sums for the next column and their holding registers.
  logic signed [SUM_W-1:0] tnext  [4];
  logic signed [SUM_W-1:0] hold_q [4];

  hdc_colsum #(.IN_W(IN_W)) i_colsum (
    .coef_i  (coef_q),
    .col_i   (next_col),
    .size2_i (size2_q),
    .t_o     (tnext)
  );

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      for (int r = 0; r < 4; r++) hold_q[r] <= '0;
    end else if (load) begin
      for (int r = 0; r < 4; r++) hold_q[r] <= tnext[r];
    end
  end

  logic signed [OUT_W-1:0] y;
  hdc_butterfly #(.SUM_W(SUM_W)) i_bfly (
    .t_i   (hold_q),
    .sel_i (sel),
    .y_o   (y)
  );

  // Output registers.
  logic emit;
  assign emit = (state == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      out_data_o  <= '0;
      out_row_o   <= '0;
      out_col_o   <= '0;
    end else begin
      out_valid_o <= emit;
      done_o      <= emit && last;
      if (emit) begin
        out_data_o <= y;
        out_row_o  <= row;
        out_col_o  <= col;
      end
    end
  end

  assign busy_o = (state != ST_IDLE);

  AST_PAIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_s)
    (state == ST_RUN && !size2_q && row[0]) |->
      ($stable(hold_q[0]) && $stable(hold_q[1]) && $stable(hold_q[2]) &&
       $stable(hold_q[3]) && $stable(sel[1]))); // R9

  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_s)
    done_o |-> (out_valid_o && out_row_o == (size2_q ? 2'd1 : 2'd3) &&
                out_col_o == (size2_q ? 2'd1 : 2'd3))); // R5

  AST_VALID_END: assert property (@(posedge clk_i) disable iff (!rst_s)
    $fell(out_valid_o) |-> $past(done_o)); // R4

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_s)
    done_o |-> !busy_o); // R5

endmodule

// File: tb/test_hdc_hadamard_dc.sv
`timescale 1ns/1ps
module test_hdc_hadamard_dc;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         size2;
  logic [255:0] coef;
  logic         busy, valid, done;
  logic [19:0]  data;
  logic [1:0]   orow, ocol;

  int checks = 0;
  int errors = 0;
  string dtag;
  int got [16];

  always #2 clk = ~clk;

  hdc_hadamard_dc i_hdc_hadamard_dc (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size2_i(size2), .coef_i(coef),
    .busy_o(busy), .out_valid_o(valid), .out_data_o(data),
    .out_row_o(orow), .out_col_o(ocol), .done_o(done)
  );

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hs(input bit s2, input int i, input int k);
    if (s2) return (i == 1 && k == 1) ? -1 : 1;
    case (i)
      0: return 1;
      1: return (k >= 2) ? -1 : 1;
      2: return (k == 1 || k == 2) ? -1 : 1;
      default: return (k == 1 || k == 3) ? -1 : 1;
    endcase
  endfunction

  task automatic start_pulse(input bit s2, input int x[16]);
    start = 1'b1;
    size2 = s2;
    for (int k = 0; k < 16; k++) coef[k*16 +: 16] = 16'(x[k]);
  endtask

  task automatic collect(input bit s2, input int x[16], input bit poke,
                         input bit chain, input bit cs2, input int cx[16]);
    int dim, n;
    int expv [16];
    int junk [16];
    dim = s2 ? 2 : 4;
    n = dim * dim;
    for (int i = 0; i < dim; i++)
      for (int j = 0; j < dim; j++) begin
        int acc;
        acc = 0;
        for (int r = 0; r < dim; r++)
          for (int c = 0; c < dim; c++)
            acc += hs(s2, i, r) * x[r*dim+c] * hs(s2, c, j);
        expv[i*dim+j] = acc;
      end
    for (int k = 0; k < 16; k++) junk[k] = 1000 + k;
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy after start", int'(busy), 1);
    chk("R4 no early valid", int'(valid), 0);
    @(negedge clk);
    chk("R4 no valid in load", int'(valid), 0);
    for (int k = 0; k < n; k++) begin
      int er, ec, act;
      @(negedge clk);
      er = s2 ? (k % 2) : (k % 4);
      ec = s2 ? (k / 2) : (k / 4);
      act = int'($signed(data));
      chk("R4 valid contiguous", int'(valid), 1);
      chk(s2 ? "R3 row order" : "R9 row order", int'(orow), er);
      chk(s2 ? "R3 col order" : "R9 col order", int'(ocol), ec);
      chk(dtag, act, expv[er*dim+ec]);
      chk("R5 done only on last", int'(done), (k == n-1) ? 1 : 0);
      if (k == n-1) chk("R5 idle with done", int'(busy), 0);
      got[er*dim+ec] = act;
      if (poke && k == 2) start_pulse(!s2, junk);
      if (poke && k == 3) start = 1'b0;
    end
    if (chain) begin
      start_pulse(cs2, cx);
    end else begin
      @(negedge clk);
      chk("R5 valid drops", int'(valid), 0);
      chk("R5 done drops", int'(done), 0);
      chk("R5 busy low", int'(busy), 0);
      if (poke) begin
        repeat (4) begin
          @(negedge clk);
          chk("R6 ignored start runs nothing", int'(valid | busy), 0);
        end
      end
    end
  endtask

  task automatic run(input bit s2, input int x[16]);
    int none [16];
    for (int k = 0; k < 16; k++) none[k] = 0;
    start_pulse(s2, x);
    collect(s2, x, 1'b0, 1'b0, 1'b0, none);
  endtask

  initial begin
    int x [16];
    int y [16];
    int none [16];
    logic [15:0] r16;
    for (int k = 0; k < 16; k++) none[k] = 0;
    rst_n = 1'b0; start = 1'b0; size2 = 1'b0; coef = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 valid idle", int'(valid), 0);
    chk("R1 done idle", int'(done), 0);

    // Impulse sweep, large-block mode.
    dtag = "R2 impulse 4x4";
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 16; k++) x[k] = 0;
      x[p] = (p + 1) * 7 - 50;
      run(1'b0, x);
    end
    // Impulse sweep, small-block mode; upper elements carry junk (R3: ignored).
    dtag = "R3 impulse 2x2";
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 16; k++) x[k] = (k >= 4) ? 12345 : 0;
      x[p] = -(p + 3) * 11;
      run(1'b1, x);
    end
    // Random full-range arrays.
    for (int t = 0; t < 10; t++) begin
      for (int k = 0; k < 16; k++) begin
        r16 = 16'($urandom());
        x[k] = int'($signed(r16));
      end
      dtag = "R2 random 4x4";
      run(1'b0, x);
      dtag = "R3 random 2x2";
      run(1'b1, x);
    end
    // Full-scale inputs.
    dtag = "R7 full scale";
    for (int k = 0; k < 16; k++) x[k] = 32767;
    run(1'b0, x);
    for (int k = 0; k < 16; k++) x[k] = -32768;
    run(1'b0, x);
    run(1'b1, x);
    for (int k = 0; k < 16; k++) x[k] = (((k / 4) + (k % 4)) % 2 == 1) ? -32768 : 32767;
    run(1'b0, x);
    for (int k = 0; k < 16; k++) x[k] = (k == 1 || k == 2) ? -32768 : 32767;
    run(1'b1, x);

    // Self-inverse.
    for (int m = 0; m < 2; m++) begin
      bit s2;
      int n;
      s2 = (m == 1);
      n = s2 ? 4 : 16;
      for (int k = 0; k < 16; k++) x[k] = int'($urandom_range(4094)) - 2047;
      dtag = "R8 first pass";
      run(s2, x);
      for (int k = 0; k < 16; k++) y[k] = (k < n) ? got[k] : 0;
      dtag = "R8 second pass";
      run(s2, y);
      for (int k = 0; k < n; k++) chk("R8 double transform", got[k], x[k] * n);
    end

    // Start during a running block.
    for (int k = 0; k < 16; k++) x[k] = k * 97 - 700;
    dtag = "R6 poked run";
    start_pulse(1'b0, x);
    collect(1'b0, x, 1'b1, 1'b0, 1'b0, none);

    // New start accepted in the cycle done is high.
    for (int k = 0; k < 16; k++) y[k] = 300 - k * 41;
    dtag = "R5 chained first";
    start_pulse(1'b0, x);
    collect(1'b0, x, 1'b0, 1'b1, 1'b1, y);
    dtag = "R5 chained second";
    collect(1'b1, y, 1'b0, 1'b0, 1'b0, none);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule